// File: doc/BRIEF.md
# 72-bit SECDED Error Codec

This block protects 64-bit memory words with eight check bits. It uses a single-error-correcting, double-error-detecting code. On the write side it produces the check byte for a data word. The check byte is stored above the data, so codeword bits 0..63 hold data and bits 64..71 hold the check bits.

On the read side the block takes a stored 72-bit codeword and computes an 8-bit syndrome against a fixed parity-check matrix. Every column of that matrix has odd weight, and the columns do not follow the classic power-of-two layout. The syndrome is then decoded into one of three outcomes:

- clean: no error was found;
- correctable: exactly one bit was found flipped, and its position is reported;
- uncorrectable: the error cannot be repaired.

The logic is combinational. A parameter selects whether a single register stage with asynchronous active-low reset sits on all outputs. With the default, that stage is present and results appear one clock after the inputs.

Column table, written as syndrome value in hex for each codeword bit:

| Codeword bits | Columns |
|---|---|
| 0..7 | F4 F1 EC EA E9 E6 E5 E3 |
| 8..15 | DC DA D9 D6 D5 D3 CE CB |
| 16..31 | B5 B0 AD AB A8 A7 A4 A2 9D 9B 98 97 94 92 8F 8A |
| 32..47 | 75 70 6D 6B 68 67 64 62 5E 5B 58 57 54 52 4F 4A |
| 48..63 | 34 31 2C 2A 29 26 25 23 1C 1A 19 16 15 13 0E 0B |
| 64..71 | 80 40 20 10 08 04 02 01 |

Top module: `secded_codec`

## Requirements
- R1: `wrCheck[k]` equals the XOR of every `wrData[i]` whose column has bit (7-k) set. `wrCheck[k]` is stored as codeword bit 64+k.
- R2: `rdSyndrome` equals the XOR of the columns of all codeword bits that are 1 in `rdWord`.
- R3: A zero syndrome gives both strobes low, `rdBitIdx` = 0, and `rdData` = `rdWord[63:0]`.
- R4: A syndrome equal to the column of data bit i (0..63) raises `rdCorrectable`, sets `rdBitIdx` = i, and outputs `rdWord[63:0]` with bit i inverted.
- R5: A syndrome equal to the column of check bit 64+k raises `rdCorrectable` and sets `rdBitIdx` = 64+k. The data is passed through unchanged.
- R6: Any nonzero syndrome of even weight, such as the one from a double-bit error, raises `rdUncorrectable`, sets `rdBitIdx` = 0, and passes the data unchanged.
- R7: A nonzero odd-weight syndrome that matches no column (for example 0x07) is treated as uncorrectable, in the same way as R6.
- R8: `rdCorrectable` and `rdUncorrectable` are never high together.
- R9: With `OUT_REG` = 1, every output reflects the inputs sampled at the previous rising clock edge. While `rstN` is low, all outputs are zero.
- R10: With `OUT_REG` = 0, every output follows its inputs within the same cycle, with the same values as the registered variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 64 | Data word to encode |
| wrCheck | output | 8 | Check bits for `wrData` |
| rdWord | input | 72 | Stored codeword: data in 63..0, check bits in 71..64 |
| rdData | output | 64 | Corrected data |
| rdSyndrome | output | 8 | Computed syndrome |
| rdBitIdx | output | 7 | Position of the repaired bit; 0 when no repair is made |
| rdCorrectable | output | 1 | Single-bit error found and repaired |
| rdUncorrectable | output | 1 | Error found that cannot be repaired |

## Verification
A wrong column in either the encoder rows or the decoder match table shows up at the ports within the same result cycle, which is one clock after the inputs when the register stage is present. That single sweep of every codeword position exposes it as one of three symptoms: a syndrome that differs from the reference XOR, a wrong reported index, or a data word that differs from the original in other than the expected bit. A broken classification shows up as both strobes high together, or as an even-weight syndrome that was not flagged. Aliasing of a triple error onto a valid column, which sends the repair to the wrong bit, is checked explicitly.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;

  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int IDX_W  = $clog2(CODE_W);

  // Control-to-datapath strobes
  typedef struct packed {
    logic             correctable;
    logic             uncorrectable;
    logic [IDX_W-1:0] flipIdx;
  } fixCtl_t;

  // Odd-weight parity-check column of data bit i
  function automatic logic [CHK_W-1:0] dataCol(input int i);
    logic [CHK_W-1:0] c;
    case (i)
      0: c = 8'hF4;   1: c = 8'hF1;   2: c = 8'hEC;   3: c = 8'hEA;
      4: c = 8'hE9;   5: c = 8'hE6;   6: c = 8'hE5;   7: c = 8'hE3;
      8: c = 8'hDC;   9: c = 8'hDA;  10: c = 8'hD9;  11: c = 8'hD6;
     12: c = 8'hD5;  13: c = 8'hD3;  14: c = 8'hCE;  15: c = 8'hCB;
     16: c = 8'hB5;  17: c = 8'hB0;  18: c = 8'hAD;  19: c = 8'hAB;
     20: c = 8'hA8;  21: c = 8'hA7;  22: c = 8'hA4;  23: c = 8'hA2;
     24: c = 8'h9D;  25: c = 8'h9B;  26: c = 8'h98;  27: c = 8'h97;
     28: c = 8'h94;  29: c = 8'h92;  30: c = 8'h8F;  31: c = 8'h8A;
     32: c = 8'h75;  33: c = 8'h70;  34: c = 8'h6D;  35: c = 8'h6B;
     36: c = 8'h68;  37: c = 8'h67;  38: c = 8'h64;  39: c = 8'h62;
     40: c = 8'h5E;  41: c = 8'h5B;  42: c = 8'h58;  43: c = 8'h57;
     44: c = 8'h54;  45: c = 8'h52;  46: c = 8'h4F;  47: c = 8'h4A;
     48: c = 8'h34;  49: c = 8'h31;  50: c = 8'h2C;  51: c = 8'h2A;
     52: c = 8'h29;  53: c = 8'h26;  54: c = 8'h25;  55: c = 8'h23;
     56: c = 8'h1C;  57: c = 8'h1A;  58: c = 8'h19;  59: c = 8'h16;
     60: c = 8'h15;  61: c = 8'h13;  62: c = 8'h0E;  63: c = 8'h0B;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Column of any codeword bit; check bits are one-hot, MSB first
  function automatic logic [CHK_W-1:0] codeCol(input int i);
    logic [CHK_W-1:0] c;
    if (i < DATA_W) c = dataCol(i);
    else            c = (CHK_W'(1) << (CHK_W - 1 - (i - DATA_W)));
    return c;
  endfunction

  // Data bits feeding check bit k (syndrome row CHK_W-1-k)
  function automatic logic [DATA_W-1:0] rowMask(input int k);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c    = dataCol(i);
      m[i] = c[CHK_W-1-k];
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_parity.sv
`timescale 1ns/1ps
module secded_parity
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] dataIn,
  output logic [CHK_W-1:0]  chkOut
);

  for (genvar k = 0; k < CHK_W; k++) begin : g_row
    localparam logic [DATA_W-1:0] ROW = rowMask(k);
    assign chkOut[k] = ^(dataIn & ROW);
  end

endmodule

// File: rtl/secded_datapath.sv
`timescale 1ns/1ps
module secded_datapath
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] wrData,
  output logic [CHK_W-1:0]  wrCheck,
  input  logic [CODE_W-1:0] rdWord,
  input  fixCtl_t           fixCtl,
  output logic [CHK_W-1:0]  syndrome,
  output logic [DATA_W-1:0] fixedData
);

  logic [CHK_W-1:0]  recCheck;
  logic [DATA_W-1:0] flipMask;
  logic [DATA_W-1:0] rawData;

  assign rawData = rdWord[DATA_W-1:0];

  secded_parity u_enc (.dataIn(wrData),  .chkOut(wrCheck));
  secded_parity u_rec (.dataIn(rawData), .chkOut(recCheck));

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    assign syndrome[CHK_W-1-k] = recCheck[k] ^ rdWord[DATA_W+k];
  end

  // Repair applies only to data positions; check-bit hits leave data alone
  always_comb begin
    flipMask = '0;
    if (fixCtl.correctable && !fixCtl.flipIdx[IDX_W-1])
      flipMask = DATA_W'(1) << fixCtl.flipIdx[IDX_W-2:0];
  end

  assign fixedData = rawData ^ flipMask;

endmodule

// File: rtl/secded_control.sv
`timescale 1ns/1ps
module secded_control
  import secded_pkg::*;
(
  input  logic [CHK_W-1:0] syndrome,
  output fixCtl_t          fixCtl
);

  logic [CODE_W-1:0] match;
  logic [IDX_W-1:0]  hitIdx;
  logic              anyHit;

  for (genvar i = 0; i < CODE_W; i++) begin : g_match
    localparam logic [CHK_W-1:0] COL = codeCol(i);
    assign match[i] = (syndrome == COL);
  end

  // Columns are distinct, so an OR-reduction encoder suffices
  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < CODE_W; i++)
      if (match[i]) hitIdx = hitIdx | IDX_W'(i);
  end

  assign anyHit = |match;

  assign fixCtl.correctable   = anyHit;
  assign fixCtl.uncorrectable = (|syndrome) && !anyHit;
  assign fixCtl.flipIdx       = hitIdx;

endmodule

// File: rtl/secded_codec.sv
`timescale 1ns/1ps
module secded_codec
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [CHK_W-1:0]  wrCheck,
  input  logic [CODE_W-1:0] rdWord,
  output logic [DATA_W-1:0] rdData,
  output logic [CHK_W-1:0]  rdSyndrome,
  output logic [IDX_W-1:0]  rdBitIdx,
  output logic              rdCorrectable,
  output logic              rdUncorrectable
);

  fixCtl_t           fixCtl;
  logic [CHK_W-1:0]  chkComb;
  logic [CHK_W-1:0]  synComb;
  logic [DATA_W-1:0] dataComb;

  secded_datapath u_dp (
    .wrData   (wrData),
    .wrCheck  (chkComb),
    .rdWord   (rdWord),
    .fixCtl   (fixCtl),
    .syndrome (synComb),
    .fixedData(dataComb)
  );

  secded_control u_ctl (
    .syndrome(synComb),
    .fixCtl  (fixCtl)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrCheck         <= '0;
        rdData          <= '0;
        rdSyndrome      <= '0;
        rdBitIdx        <= '0;
        rdCorrectable   <= 1'b0;
        rdUncorrectable <= 1'b0;
      end else begin
        wrCheck         <= chkComb;
        rdData          <= dataComb;
        rdSyndrome      <= synComb;
        rdBitIdx        <= fixCtl.flipIdx;
        rdCorrectable   <= fixCtl.correctable;
        rdUncorrectable <= fixCtl.uncorrectable;
      end
    end
  end else begin : g_comb
    assign wrCheck         = chkComb;
    assign rdData          = dataComb;
    assign rdSyndrome      = synComb;
    assign rdBitIdx        = fixCtl.flipIdx;
    assign rdCorrectable   = fixCtl.correctable;
    assign rdUncorrectable = fixCtl.uncorrectable;
  end

endmodule

// File: rtl/secded_codec_chk.sv
`timescale 1ns/1ps
module secded_codec_chk
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] rdWordData,
  input logic [DATA_W-1:0] rdData,
  input logic [CHK_W-1:0]  rdSyndrome,
  input logic [IDX_W-1:0]  rdBitIdx,
  input logic              rdCorrectable,
  input logic              rdUncorrectable
);

  logic [DATA_W-1:0] prevRaw;
  logic [DATA_W-1:0] rawRef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevRaw <= '0;
    else       prevRaw <= rdWordData;
  end

  assign rawRef = OUT_REG ? prevRaw : rdWordData;

  // R8
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rdCorrectable && rdUncorrectable));

  // R3
  a_r3_zero_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rdSyndrome == '0) |-> (!rdCorrectable && !rdUncorrectable && rdData == rawRef));

  // R6
  a_r6_even_flagged: assert property (@(posedge clk) disable iff (!rstN)
    ((rdSyndrome != '0) && !(^rdSyndrome)) |-> (rdUncorrectable && rdData == rawRef));

  // R5
  a_r5_check_hit_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    (rdCorrectable && rdBitIdx[IDX_W-1]) |-> (rdData == rawRef));

  // R4
  a_r4_single_repair: assert property (@(posedge clk) disable iff (!rstN)
    (rdCorrectable && !rdBitIdx[IDX_W-1]) |-> ($countones(rdData ^ rawRef) == 1));

  // R7
  a_r7_unknown_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    rdUncorrectable |-> (rdData == rawRef && rdBitIdx == '0));

endmodule

bind secded_codec secded_codec_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .rdWordData     (rdWord[63:0]),
  .rdData         (rdData),
  .rdSyndrome     (rdSyndrome),
  .rdBitIdx       (rdBitIdx),
  .rdCorrectable  (rdCorrectable),
  .rdUncorrectable(rdUncorrectable)
);

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] wrData = '0;
  logic [71:0] rdWord = '0;
  logic [7:0]  wrCheck, wrCheckC;
  logic [63:0] rdData, rdDataC;
  logic [7:0]  rdSyndrome, rdSyndromeC;
  logic [6:0]  rdBitIdx, rdBitIdxC;
  logic        rdCorrectable, rdCorrectableC, rdUncorrectable, rdUncorrectableC;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  secded_codec #(.OUT_REG(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrCheck(wrCheck), .rdWord(rdWord),
    .rdData(rdData), .rdSyndrome(rdSyndrome), .rdBitIdx(rdBitIdx),
    .rdCorrectable(rdCorrectable), .rdUncorrectable(rdUncorrectable));

  secded_codec #(.OUT_REG(1'b0)) u_comb (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrCheck(wrCheckC), .rdWord(rdWord),
    .rdData(rdDataC), .rdSyndrome(rdSyndromeC), .rdBitIdx(rdBitIdxC),
    .rdCorrectable(rdCorrectableC), .rdUncorrectable(rdUncorrectableC));

  // Reference columns, from the requirement table
  function automatic logic [7:0] colOf(input int i);
    logic [7:0] t [64];
    t = '{8'hF4,8'hF1,8'hEC,8'hEA,8'hE9,8'hE6,8'hE5,8'hE3,
          8'hDC,8'hDA,8'hD9,8'hD6,8'hD5,8'hD3,8'hCE,8'hCB,
          8'hB5,8'hB0,8'hAD,8'hAB,8'hA8,8'hA7,8'hA4,8'hA2,
          8'h9D,8'h9B,8'h98,8'h97,8'h94,8'h92,8'h8F,8'h8A,
          8'h75,8'h70,8'h6D,8'h6B,8'h68,8'h67,8'h64,8'h62,
          8'h5E,8'h5B,8'h58,8'h57,8'h54,8'h52,8'h4F,8'h4A,
          8'h34,8'h31,8'h2C,8'h2A,8'h29,8'h26,8'h25,8'h23,
          8'h1C,8'h1A,8'h19,8'h16,8'h15,8'h13,8'h0E,8'h0B};
    if (i < 64) return t[i];
    return 8'h80 >> (i - 64);
  endfunction

  function automatic logic [7:0] refCheck(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++)
      for (int k = 0; k < 8; k++)
        if (d[i] && colOf(i)[7-k]) c[k] = ~c[k];
    return c;
  endfunction

  function automatic logic [7:0] refSyn(input logic [71:0] w);
    logic [7:0] s = '0;
    for (int i = 0; i < 72; i++) if (w[i]) s ^= colOf(i);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // {data, error mask, class (0 clean,1 corr,2 uncorr), index}
  localparam logic [144:0] VECS [11] = '{
    {64'h0000_0000_0000_0000, 72'h0,                     2'd0, 7'd0},
    {64'hDEAD_BEEF_0123_4567, 72'h0,                     2'd0, 7'd0},
    {64'h0101_0101_0101_0101, 72'h00_0000_0000_1000_0000, 2'd1, 7'd28},
    {64'hFFFF_FFFF_FFFF_FFFF, 72'h1,                     2'd1, 7'd0},
    {64'hA5A5_A5A5_A5A5_A5A5, 72'h00_8000_0000_0000_0000, 2'd1, 7'd63},
    {64'h0123_4567_89AB_CDEF, 72'h01_0000_0000_0000_0000, 2'd1, 7'd64},
    {64'hFFFF_0000_FFFF_0000, 72'h80_0000_0000_0000_0000, 2'd1, 7'd71},
    {64'h0101_0101_0101_0101, 72'h00_1000_0000_0000_0008, 2'd2, 7'd0},
    {64'h0000_0000_0000_0000, 72'h03_0000_0000_0000_0000, 2'd2, 7'd0},
    {64'h5555_5555_5555_5555, 72'hE0_0000_0000_0000_0000, 2'd2, 7'd0},
    {64'h0000_0000_0000_0000, 72'h7,                     2'd1, 7'd4}
  };

  // Drive at negedge, compare at next negedge (one register on the path)
  task automatic runVec(input logic [63:0] d, input logic [71:0] flip,
                        input int cls, input int idx, input string req);
    logic [71:0] w;
    logic [63:0] expData;
    w = {refCheck(d), d} ^ flip;
    expData = w[63:0];
    if (cls == 1 && idx < 64) expData[idx] = ~expData[idx];
    @(negedge clk);
    wrData = d;
    rdWord = w;
    @(negedge clk);
    check(wrCheck == refCheck(d), "R1", "encoder", 72'(wrCheck), 72'(refCheck(d)));
    check(rdSyndrome == refSyn(w), "R2", "syndrome", 72'(rdSyndrome), 72'(refSyn(w)));
    check(rdCorrectable == (cls == 1) && rdUncorrectable == (cls == 2), req, "strobes",
          72'({rdCorrectable, rdUncorrectable}), 72'({cls == 1, cls == 2}));
    check(!(rdCorrectable && rdUncorrectable), "R8", "both strobes",
          72'({rdCorrectable, rdUncorrectable}), 72'(0));
    check(rdBitIdx == 7'(idx), req, "index", 72'(rdBitIdx), 72'(idx));
    check(rdData == expData, req, "data", 72'(rdData), 72'(expData));
    check({wrCheckC, rdDataC, rdSyndromeC, rdBitIdxC, rdCorrectableC, rdUncorrectableC} ==
          {wrCheck, rdData, rdSyndrome, rdBitIdx, rdCorrectable, rdUncorrectable},
          "R10", "comb vs reg", 72'(rdDataC), 72'(rdData));
  endtask

  function automatic string reqOf(input int cls, input int idx, input logic [71:0] flip);
    if (cls == 0) return "R3";
    if (cls == 1) return (idx >= 64) ? "R5" : "R4";
    return ($countones(flip) > 2) ? "R7" : "R6";
  endfunction

  initial begin
    #200_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9 reset state with nonzero inputs
    wrData = 64'hFFFF_FFFF_FFFF_FFFF;
    rdWord = 72'h3;
    repeat (3) @(negedge clk);
    check(rdData == 0 && wrCheck == 0 && rdSyndrome == 0 && !rdCorrectable &&
          !rdUncorrectable && rdBitIdx == 0, "R9", "reset outputs", 72'(rdData), 72'(0));
    rstN = 1'b1;

    foreach (VECS[v]) begin
      logic [63:0] d;
      logic [71:0] f;
      int c;
      int ix;
      d  = VECS[v][144:81];
      f  = VECS[v][80:9];
      c  = int'(VECS[v][8:7]);
      ix = int'(VECS[v][6:0]);
      runVec(d, f, c, ix, reqOf(c, ix, f));
    end

    // Every single-bit position (R4, R5)
    for (int p = 0; p < 72; p++)
      runVec({32'hC0FF_EE00 + 32'(p), 32'h1357_9BDF ^ 32'(p * 7)}, 72'(1) << p, 1, p,
             (p < 64) ? "R4" : "R5");

    // Adjacent double-bit errors (R6)
    for (int p = 0; p < 71; p++)
      runVec({32'h2468_ACE0 ^ 32'(p), 32'hF0E1_D2C3}, (72'(3) << p), 2, 0, "R6");

    // R9 latency: the output holds until the next edge
    @(negedge clk);
    wrData = '0;
    rdWord = {refCheck(64'h1), 64'h1} ^ 72'h2;
    #1;
    check(rdCorrectable == 1'b0 && rdUncorrectable == 1'b1, "R9", "held before edge",
          72'({rdCorrectable, rdUncorrectable}), 72'(1));
    @(negedge clk);
    check(rdCorrectable && rdBitIdx == 7'd1 && rdData == 64'h1, "R9", "one-cycle latency",
          72'(rdData), 72'h1);

    // R9 asynchronous reset mid-run
    #2 rstN = 1'b0;
    #1;
    check(rdData == 0 && !rdCorrectable && rdBitIdx == 0, "R9", "async reset",
          72'(rdData), 72'(0));
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule